// File: doc/BRIEF.md
# TFT Panel Scan Timing and Frame Fetch Controller

This block drives a parallel 24-bit RGB thin-film panel with a 320 by 240 visible area. Its only timebase is a fast system clock. A divider turns that clock into a pixel-rate enable and a square-wave pixel clock for the panel. Two cascaded counters step through every position of a line and every line of a frame. From their state the block decodes the active-low line and frame sync pulses and a data-enable flag.

While the scan position lies inside the visible window, the block issues one read strobe per pixel to an external frame memory. The strobe carries a linear address that runs from zero across the whole picture. The memory answers one system cycle later. The returned word is held and shown on the next pixel, so the read address leads the panel data by one pixel. The sync and data-enable outputs pass through the same two-stage pipeline, so all panel outputs stay aligned with each other. Every timing count is a parameter. The defaults give a 408-pixel line and a 262-line frame, which is about 58 frames per second at a 6.25 MHz pixel rate from a 100 MHz clock.

Top module: `lcd_tft_ctrl`

## Requirements
- R1: The pixel enable fires on one system cycle in every 16. `lcd_pclk` has a period of 16 system cycles, is low for the first 8 divider counts and high for the last 8, and is low right after reset.
- R2: A line is 408 pixel periods long. Counts 0 to 67 are back porch, 68 to 387 are active and 388 to 407 are front porch. `lcd_hsync_n` is low for the first 20 counts of the back porch and high otherwise.
- R3: A frame is 262 lines long. Lines 0 to 17 are back porch, 18 to 257 are active and 258 to 261 are front porch. `lcd_vsync_n` is low for the first 10 lines of the back porch and high otherwise.
- R4: `lcd_de` is high only for pixels that are in both the active columns and the active lines. This gives 320 pixels on each of 240 lines. While `lcd_de` is high, both sync outputs are high.
- R5: `lcd_rgb` is all zeros whenever `lcd_de` is low.
- R6: `mem_rd` is a single-cycle strobe, issued on the pixel-enable cycle of each active pixel. `mem_addr` is 0 for the first active pixel of a frame and goes up by one for each active pixel, in row-major order, up to 76799. It then wraps to 0. `mem_addr` does not change during blanking.
- R7: The panel outputs lag the scan counters by two pixel periods. The word shown on the panel during active pixel k of a frame is the memory word at address k. That word was read one pixel period before it appears on the panel.
- R8: A synchronous active-high reset clears the divider, the counters, the address and the pipeline. After a reset edge, `lcd_hsync_n` and `lcd_vsync_n` are high, `lcd_de` is low, `lcd_rgb` is zero, `lcd_pclk` is low and `mem_rd` is low.
- R9: The sync outputs, `lcd_de` and `lcd_rgb` change only on the system edge that ends a pixel-enable cycle. They hold steady for the 15 system cycles between such edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd | output | 1 | Frame memory read strobe, one system cycle wide |
| mem_addr | output | 17 | Linear pixel address of the read |
| mem_data | input | 24 | Word returned by the memory one system cycle after the read |
| lcd_pclk | output | 1 | Pixel clock to the panel, 50% duty cycle |
| lcd_hsync_n | output | 1 | Line sync, active low |
| lcd_vsync_n | output | 1 | Frame sync, active low |
| lcd_de | output | 1 | Data enable for the visible window |
| lcd_rgb | output | 24 | Pixel colour, red in bits 23:16, green in 15:8, blue in 7:0 |

## Verification
The assertions check, on every cycle, the properties that depend only on neighbouring cycles. These are blanked colour outside data-enable and sync held high during data-enable. They also cover a single-cycle read strobe, an address that moves only after a read, outputs that hold between pixel enables, the pixel clock period and the state just after reset. What no local property can show is where each region lies within a line or frame, and whether the word on the panel belongs to the right pixel. The bench covers both by comparing every cycle against a position model. It runs a scaled-down geometry over several frames, with a random reset in mid-scan, alongside a default-sized instance that runs into the first visible line.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

    localparam int RGB_W = 24;

    typedef logic [RGB_W-1:0] rgb_t;

    // Decoded scan position flags for one pixel
    typedef struct packed {
        logic act;
        logic hs_n;
        logic vs_n;
    } scan_t;

    localparam scan_t SCAN_IDLE = '{act: 1'b0, hs_n: 1'b1, vs_n: 1'b1};

endpackage

// File: rtl/lcd_clk_div.sv
module lcd_clk_div #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic pclk
);

    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] CNT_HALF = CW'(DIV / 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (rst) begin
            div_d.cnt = '0;
        end else if (div_q.cnt == CNT_LAST) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        div_q <= div_d;
    end

    assign tick = (div_q.cnt == CNT_LAST);
    assign pclk = (div_q.cnt >= CNT_HALF);

endmodule

// File: rtl/lcd_scan_ctr.sv
module lcd_scan_ctr
    import lcd_tim_pkg::*;
#(
    parameter int H_SYNC = 20,
    parameter int H_BP   = 68,
    parameter int H_ACT  = 320,
    parameter int H_FP   = 20,
    parameter int V_SYNC = 10,
    parameter int V_BP   = 18,
    parameter int V_ACT  = 240,
    parameter int V_FP   = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    output scan_t flags
);

    localparam int H_TOT = H_BP + H_ACT + H_FP;
    localparam int V_TOT = V_BP + V_ACT + V_FP;
    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);

    localparam logic [HW-1:0] H_LAST  = HW'(H_TOT - 1);
    localparam logic [VW-1:0] V_LAST  = VW'(V_TOT - 1);
    localparam logic [HW-1:0] H_SEND  = HW'(H_SYNC);
    localparam logic [VW-1:0] V_SEND  = VW'(V_SYNC);
    localparam logic [HW-1:0] H_AFST  = HW'(H_BP);
    localparam logic [HW-1:0] H_AEND  = HW'(H_BP + H_ACT);
    localparam logic [VW-1:0] V_AFST  = VW'(V_BP);
    localparam logic [VW-1:0] V_AEND  = VW'(V_BP + V_ACT);

    typedef struct packed {
        logic [HW-1:0] col;
        logic [VW-1:0] row;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (rst) begin
            pos_d.col = '0;
            pos_d.row = '0;
        end else if (tick) begin
            if (pos_q.col == H_LAST) begin
                pos_d.col = '0;
                pos_d.row = (pos_q.row == V_LAST) ? '0 : pos_q.row + 1'b1;
            end else begin
                pos_d.col = pos_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        pos_q <= pos_d;
    end

    always_comb begin
        flags.act  = (pos_q.col >= H_AFST) && (pos_q.col < H_AEND) &&
                     (pos_q.row >= V_AFST) && (pos_q.row < V_AEND);
        flags.hs_n = !(pos_q.col < H_SEND);
        flags.vs_n = !(pos_q.row < V_SEND);
    end

endmodule

// File: rtl/lcd_fetch.sv
module lcd_fetch
    import lcd_tim_pkg::*;
#(
    parameter int H_ACT = 320,
    parameter int V_ACT = 240,
    parameter int AW    = $clog2(H_ACT * V_ACT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  scan_t         cur,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  rgb_t          mem_data,
    output logic          hs_n,
    output logic          vs_n,
    output logic          de,
    output rgb_t          rgb
);

    localparam logic [AW-1:0] ADDR_LAST = AW'(H_ACT * V_ACT - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        scan_t         stage;
        scan_t         outf;
        rgb_t          pix;
    } fetch_st_t;

    fetch_st_t fs_d, fs_q;

    always_comb begin
        fs_d = fs_q;
        if (rst) begin
            fs_d.addr  = '0;
            fs_d.stage = SCAN_IDLE;
            fs_d.outf  = SCAN_IDLE;
            fs_d.pix   = '0;
        end else if (tick) begin
            if (cur.act) begin
                fs_d.addr = (fs_q.addr == ADDR_LAST) ? '0 : fs_q.addr + 1'b1;
            end
            fs_d.stage = cur;
            fs_d.outf  = fs_q.stage;
            fs_d.pix   = fs_q.stage.act ? mem_data : '0;
        end
    end

    always_ff @(posedge clk) begin
        fs_q <= fs_d;
    end

    assign mem_rd   = tick && cur.act;
    assign mem_addr = fs_q.addr;
    assign hs_n     = fs_q.outf.hs_n;
    assign vs_n     = fs_q.outf.vs_n;
    assign de       = fs_q.outf.act;
    assign rgb      = fs_q.pix;

endmodule

// File: rtl/lcd_tft_ctrl.sv
module lcd_tft_ctrl
    import lcd_tim_pkg::*;
#(
    parameter int DIV    = 16,
    parameter int H_SYNC = 20,
    parameter int H_BP   = 68,
    parameter int H_ACT  = 320,
    parameter int H_FP   = 20,
    parameter int V_SYNC = 10,
    parameter int V_BP   = 18,
    parameter int V_ACT  = 240,
    parameter int V_FP   = 4,
    localparam int AW    = $clog2(H_ACT * V_ACT)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [23:0]   mem_data,
    output logic          lcd_pclk,
    output logic          lcd_hsync_n,
    output logic          lcd_vsync_n,
    output logic          lcd_de,
    output logic [23:0]   lcd_rgb
);

    logic  pix_tick;
    scan_t scan_now;

    lcd_clk_div #(
        .DIV (DIV)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (pix_tick),
        .pclk (lcd_pclk)
    );

    lcd_scan_ctr #(
        .H_SYNC (H_SYNC),
        .H_BP   (H_BP),
        .H_ACT  (H_ACT),
        .H_FP   (H_FP),
        .V_SYNC (V_SYNC),
        .V_BP   (V_BP),
        .V_ACT  (V_ACT),
        .V_FP   (V_FP)
    ) u_scan (
        .clk   (clk),
        .rst   (rst),
        .tick  (pix_tick),
        .flags (scan_now)
    );

    lcd_fetch #(
        .H_ACT (H_ACT),
        .V_ACT (V_ACT),
        .AW    (AW)
    ) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .tick     (pix_tick),
        .cur      (scan_now),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .hs_n     (lcd_hsync_n),
        .vs_n     (lcd_vsync_n),
        .de       (lcd_de),
        .rgb      (lcd_rgb)
    );

endmodule

// File: rtl/lcd_tft_ctrl_chk.sv
module lcd_tft_ctrl_chk #(
    parameter int DIV = 16,
    parameter int AW  = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          pix_tick,
    input logic          lcd_pclk,
    input logic          lcd_hsync_n,
    input logic          lcd_vsync_n,
    input logic          lcd_de,
    input logic [23:0]   lcd_rgb,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr
);

    // Cycles since the last rising edge of the pixel clock
    int   since_rise;
    logic seen_rise;
    logic pclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rise <= 0;
            seen_rise  <= 1'b0;
            pclk_prev  <= 1'b0;
        end else begin
            pclk_prev <= lcd_pclk;
            if (lcd_pclk && !pclk_prev) begin
                since_rise <= 1;
                seen_rise  <= 1'b1;
            end else begin
                since_rise <= since_rise + 1;
            end
        end
    end

    assert_pclk_period_R1: assert property (@(posedge clk) disable iff (rst)
        (seen_rise && lcd_pclk && !pclk_prev) |-> (since_rise == DIV));

    assert_de_outside_sync_R4: assert property (@(posedge clk) disable iff (rst)
        lcd_de |-> (lcd_hsync_n && lcd_vsync_n));

    assert_rgb_blank_R5: assert property (@(posedge clk) disable iff (rst)
        !lcd_de |-> (lcd_rgb == 24'd0));

    assert_rd_single_R6: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    assert_addr_moves_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_addr != $past(mem_addr)) |-> $past(mem_rd));

    assert_reset_state_R8: assert property (@(posedge clk)
        $past(rst) |-> (lcd_hsync_n && lcd_vsync_n && !lcd_de &&
                        lcd_rgb == 24'd0 && !lcd_pclk && !mem_rd));

    assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(pix_tick) |-> ($stable(lcd_de) && $stable(lcd_hsync_n) &&
                              $stable(lcd_vsync_n) && $stable(lcd_rgb)));

endmodule

bind lcd_tft_ctrl lcd_tft_ctrl_chk #(
    .DIV (DIV),
    .AW  (AW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_tick    (pix_tick),
    .lcd_pclk    (lcd_pclk),
    .lcd_hsync_n (lcd_hsync_n),
    .lcd_vsync_n (lcd_vsync_n),
    .lcd_de      (lcd_de),
    .lcd_rgb     (lcd_rgb),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr)
);

// File: tb/lcd_tft_ctrl_bench.sv
module lcd_tft_ctrl_bench;

    // Scaled geometry for the multi-frame instance
    localparam int BDIV = 16;
    localparam int S_HS = 3, S_HBP = 5, S_HACT = 8, S_HFP = 3;
    localparam int S_VS = 2, S_VBP = 4, S_VACT = 6, S_VFP = 2;
    localparam int S_AW = $clog2(S_HACT * S_VACT);
    // Default geometry
    localparam int F_HS = 20, F_HBP = 68, F_HACT = 320, F_HFP = 20;
    localparam int F_VS = 10, F_VBP = 18, F_VACT = 240, F_VFP = 4;
    localparam int F_AW = 17;
    localparam int RUN_CYC = 124000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_s, rst_f;
    logic rd_s, rd_f;
    logic [S_AW-1:0] addr_s;
    logic [F_AW-1:0] addr_f;
    logic [23:0] dat_s, dat_f, rgb_s, rgb_f;
    logic pclk_s, pclk_f, hs_s, hs_f, vs_s, vs_f, de_s, de_f;

    lcd_tft_ctrl #(
        .DIV(BDIV), .H_SYNC(S_HS), .H_BP(S_HBP), .H_ACT(S_HACT), .H_FP(S_HFP),
        .V_SYNC(S_VS), .V_BP(S_VBP), .V_ACT(S_VACT), .V_FP(S_VFP)
    ) u_lcd_tft_ctrl (
        .clk(clk), .rst(rst_s), .mem_rd(rd_s), .mem_addr(addr_s), .mem_data(dat_s),
        .lcd_pclk(pclk_s), .lcd_hsync_n(hs_s), .lcd_vsync_n(vs_s), .lcd_de(de_s),
        .lcd_rgb(rgb_s)
    );

    lcd_tft_ctrl u_lcd_tft_ctrl_full (
        .clk(clk), .rst(rst_f), .mem_rd(rd_f), .mem_addr(addr_f), .mem_data(dat_f),
        .lcd_pclk(pclk_f), .lcd_hsync_n(hs_f), .lcd_vsync_n(vs_f), .lcd_de(de_f),
        .lcd_rgb(rgb_f)
    );

    int checks = 0;
    int errors = 0;
    int n_s = 0;
    int n_f = 0;
    logic [31:0] key = 32'd0;
    logic armed = 1'b0;
    logic done = 1'b0;

    typedef struct packed {
        logic        pclk;
        logic        rd;
        logic [31:0] addr;
        logic        hs_n;
        logic        vs_n;
        logic        de;
        logic [23:0] rgb;
    } exp_t;

    function automatic logic [23:0] pat(int a, logic [31:0] k);
        logic [31:0] t;
        t = (32'(a) * 32'h9E3779B1) ^ k;
        return t[23:0] ^ t[31:8];
    endfunction

    // Expected port values after n non-reset edges since the last reset edge
    function automatic exp_t model(int n, int hs, int hbp, int hact, int hfp,
                                   int vs, int vbp, int vact, int vfp, logic [31:0] k);
        exp_t e;
        int ht = hbp + hact + hfp;
        int vt = vbp + vact + vfp;
        int p, q, h, v;
        logic a;
        e.pclk = ((n % BDIV) >= BDIV / 2);
        p = n / BDIV;
        h = p % ht;
        v = (p / ht) % vt;
        a = (h >= hbp) && (h < hbp + hact) && (v >= vbp) && (v < vbp + vact);
        e.rd = ((n % BDIV) == BDIV - 1) && a;
        e.addr = a ? 32'((v - vbp) * hact + (h - hbp)) : 32'd0;
        q = n / BDIV - 2;
        if (q < 0) begin
            e.hs_n = 1'b1; e.vs_n = 1'b1; e.de = 1'b0; e.rgb = 24'd0;
        end else begin
            h = q % ht;
            v = (q / ht) % vt;
            e.hs_n = !(h < hs);
            e.vs_n = !(v < vs);
            e.de = (h >= hbp) && (h < hbp + hact) && (v >= vbp) && (v < vbp + vact);
            e.rgb = e.de ? pat((v - vbp) * hact + (h - hbp), k) : 24'd0;
        end
        return e;
    endfunction

    task automatic chk(string tag, string what, int n, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s n=%0d actual=%0h expected=%0h", tag, what, n, act, exp);
        end
    endtask

    // R8 on reset cycles, R9 for output moves between pixel edges
    task automatic compare(string who, int n, exp_t e, logic pclk, logic rd,
                           logic [31:0] addr, logic hs, logic vs, logic de,
                           logic [23:0] rgb);
        string mid;
        mid = (n == 0) ? "R8" : ((n % BDIV) != 0 ? "R9" : "");
        chk((n == 0) ? "R8" : "R1", {who, " pclk"}, n, 32'(pclk), 32'(e.pclk));
        chk((n == 0) ? "R8" : "R6", {who, " mem_rd"}, n, 32'(rd), 32'(e.rd));
        if (e.rd) chk("R6", {who, " mem_addr"}, n, addr, e.addr);
        chk(mid != "" ? mid : "R2", {who, " hsync_n"}, n, 32'(hs), 32'(e.hs_n));
        chk(mid != "" ? mid : "R3", {who, " vsync_n"}, n, 32'(vs), 32'(e.vs_n));
        chk(mid != "" ? mid : "R4", {who, " de"}, n, 32'(de), 32'(e.de));
        chk(mid != "" ? mid : (e.de ? "R7" : "R5"), {who, " rgb"}, n, 32'(rgb), 32'(e.rgb));
    endtask

    // Frame memory models: word valid one system cycle after the strobe
    always @(posedge clk) begin
        if (rd_s) dat_s <= pat(int'(addr_s), key);
        if (rd_f) dat_f <= pat(int'(addr_f), key ^ 32'h00A5_5A3C);
        n_s <= rst_s ? 0 : n_s + 1;
        n_f <= rst_f ? 0 : n_f + 1;
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            compare("small", n_s,
                    model(n_s, S_HS, S_HBP, S_HACT, S_HFP, S_VS, S_VBP, S_VACT, S_VFP, key),
                    pclk_s, rd_s, 32'(addr_s), hs_s, vs_s, de_s, rgb_s);
            compare("full", n_f,
                    model(n_f, F_HS, F_HBP, F_HACT, F_HFP, F_VS, F_VBP, F_VACT, F_VFP,
                          key ^ 32'h00A5_5A3C),
                    pclk_f, rd_f, 32'(addr_f), hs_f, vs_f, de_f, rgb_f);
        end
    end

    initial begin
        int wait1, hold;
        key = $urandom(32'd777);
        key = $urandom;
        rst_s = 1'b1;
        rst_f = 1'b1;
        repeat (4) @(negedge clk);
        armed = 1'b1;
        rst_s = 1'b0;
        rst_f = 1'b0;
        // Random mid-scan reset of the scaled instance (R8), then more frames
        wait1 = 4000 + int'($urandom % 2000);
        hold = 1 + int'($urandom % 4);
        repeat (wait1) @(negedge clk);
        rst_s = 1'b1;
        repeat (hold) @(negedge clk);
        rst_s = 1'b0;
        // Directed: reset landing exactly on a pixel-enable cycle
        repeat (3072 * 2 + 15) @(negedge clk);
        rst_s = 1'b1;
        @(negedge clk);
        rst_s = 1'b0;
        repeat (RUN_CYC - wait1 - hold - 3072 * 2 - 16) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule